// File: doc/BRIEF.md
# Runtime-Ratio Clock Divider

This block divides its input clock by a ratio N that is chosen at runtime. A free-running synchronous counter steps through the positions 0 to N-1 and then starts again at zero. Two registered outputs come from that counter.

The first output is a strobe that is one input cycle wide and appears once in every output period. It is meant to be used as a clock enable, not as a clock. The second output is a square wave with no glitches, for logic that needs a clock-like signal. When N is a power of two, the square wave is tapped from the counter bit of weight N/2. For any other ratio, a magnitude compare against N/2 decides the level, and the result is registered before it leaves the block.

A new ratio is taken in only when a period completes, so a period that is under way always finishes at its full length. Deasserting the enable freezes the counter and both outputs.

Top module: `ratio_clk_divider`

## Requirements
- R1: A ratio input of 0 behaves exactly like a ratio of 1. The effective ratio N is the ratio input when it is nonzero, and 1 otherwise.
- R2: On each enabled edge the count advances by one. When the count reaches N-1, the next enabled edge returns it to 0. The strobe is high exactly in the cycles where the count equals N-1, which gives one single-cycle pulse every N enabled cycles.
- R3: While the synchronous reset is high, every clock edge clears the count to 0, drives both outputs low and loads the effective ratio from the ratio input.
- R4: The square wave is high exactly in the cycles where the count is at least floor(N/2), so each period starts with its low phase. For even N it stays high for N/2 cycles and low for N/2 cycles. For odd N it stays high for (N+1)/2 cycles and low for (N-1)/2 cycles.
- R5: When N is a power of two of at least 2, the square wave equals bit log2(N)-1 of the count. For example, it equals count bit 2 when N=8.
- R6: With N=10 and the enable held high, every 10 input cycles hold exactly one strobe pulse and exactly one rising edge of the square wave.
- R7: A change on the ratio input is loaded only on the enabled edge that wraps the count from N-1 to 0. The period already under way keeps its old length.
- R8: With N=1, both the strobe and the square wave are high after every enabled edge.
- R9: While the enable is low, the count, the strobe and the square wave all keep their values.
- R10: Both outputs come from registers. From the first enabled edge after reset, they reflect the count and ratio that the same edge produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| ratio | input | RATIO_W | Requested divide ratio (0 behaves as 1) |
| strobe | output | 1 | One-cycle terminal-count pulse |
| sq_out | output | 1 | Registered square-wave output |

## Verification
Two events can fall on the same edge: the wrap at the end of a period and the loading of a new ratio. To provoke this, the bench changes the ratio input during the cycle in which the strobe is high. It then checks two things: that the very next period already has the new length, and that a ratio change made in the middle of a period only takes effect after the wrap. A second coincidence is the enable dropping while the strobe is high. Here the bench checks that the strobe stays high and that no extra count step is taken.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // How the square-wave level is derived for the active ratio
    typedef enum logic {
        SHAPE_CMP = 1'b0,
        SHAPE_TAP = 1'b1
    } shape_mode_e;

endpackage

// File: rtl/rcd_counter.sv
module rcd_counter #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic [RATIO_W-1:0] cnt_q,
    output logic [RATIO_W-1:0] act_q,
    output logic [RATIO_W-1:0] cnt_nx,
    output logic [RATIO_W-1:0] act_nx
);
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] act;
    } cstate_t;

    cstate_t            st_d, st_q;
    logic [RATIO_W-1:0] eff_ratio;
    logic               at_end;

    always_comb begin
        eff_ratio = (ratio == '0) ? ONE : ratio;
        at_end    = (st_q.cnt == st_q.act - ONE);
        st_d      = st_q;
        if (rst) begin
            st_d.cnt = '0;
            st_d.act = eff_ratio;
        end else if (en) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.act = eff_ratio;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign act_q  = st_q.act;
    assign cnt_nx = st_d.cnt;
    assign act_nx = st_d.act;
endmodule

// File: rtl/rcd_shaper.sv
module rcd_shaper
    import rcd_pkg::*;
#(
    parameter int RATIO_W     = 8,
    parameter bit USE_BIT_TAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [RATIO_W-1:0] cnt_nx,
    input  logic [RATIO_W-1:0] act_nx,
    output logic               strobe,
    output logic               sq_out
);
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic strobe;
        logic sq;
    } ostate_t;

    ostate_t            os_d, os_q;
    logic [RATIO_W-1:0] half;
    logic               sq_cmp;
    logic               sq_tap;
    shape_mode_e        mode;

    assign half   = act_nx >> 1;
    assign sq_cmp = (cnt_nx >= half);

    generate
        if (USE_BIT_TAP) begin : g_tap
            logic pow2;
            assign pow2   = ((act_nx & (act_nx - ONE)) == '0) && (act_nx > ONE);
            assign mode   = pow2 ? SHAPE_TAP : SHAPE_CMP;
            // Since count < N, the single set bit of N/2 is the tap
            assign sq_tap = |(cnt_nx & half);
        end else begin : g_cmp_only
            assign mode   = SHAPE_CMP;
            assign sq_tap = 1'b0;
        end
    endgenerate

    always_comb begin
        os_d = os_q;
        if (rst) begin
            os_d.strobe = 1'b0;
            os_d.sq     = 1'b0;
        end else if (en) begin
            os_d.strobe = (cnt_nx == act_nx - ONE);
            os_d.sq     = (mode == SHAPE_TAP) ? sq_tap : sq_cmp;
        end
    end

    always_ff @(posedge clk) begin
        os_q <= os_d;
    end

    assign strobe = os_q.strobe;
    assign sq_out = os_q.sq;
endmodule

// File: rtl/ratio_clk_divider.sv
module ratio_clk_divider #(
    parameter int RATIO_W     = 8,
    parameter bit USE_BIT_TAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               strobe,
    output logic               sq_out
);
    logic [RATIO_W-1:0] cnt_q, act_q, cnt_nx, act_nx;

    rcd_counter #(.RATIO_W(RATIO_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ratio  (ratio),
        .cnt_q  (cnt_q),
        .act_q  (act_q),
        .cnt_nx (cnt_nx),
        .act_nx (act_nx)
    );

    rcd_shaper #(.RATIO_W(RATIO_W), .USE_BIT_TAP(USE_BIT_TAP)) u_shp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt_nx (cnt_nx),
        .act_nx (act_nx),
        .strobe (strobe),
        .sq_out (sq_out)
    );
endmodule

// File: rtl/rcd_chk.sv
module rcd_chk #(
    parameter int RATIO_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               strobe,
    input logic               sq_out,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] act
);
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!strobe && !sq_out && cnt == '0));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == act - ONE) |=> cnt == '0);

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != act - ONE) |=> cnt == $past(cnt) + ONE);

    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(en && cnt == act - ONE) |=> $stable(act));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(strobe) && $stable(sq_out) && $stable(cnt)));

    // R4
    square_level_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst)) |-> (sq_out == (cnt >= (act >> 1))));

    // R2
    strobe_pos_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst)) |-> (strobe == (cnt == act - ONE)));

    // R1
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        act != '0);
endmodule

bind ratio_clk_divider rcd_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .strobe (strobe),
    .sq_out (sq_out),
    .cnt    (cnt_q),
    .act    (act_q)
);

// File: tb/ratio_clk_divider_tb.sv
module ratio_clk_divider_tb;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [RW-1:0] ratio = 8'd4;
    logic          strobe, sq_out;

    int total = 0;
    int bad   = 0;

    // reference state, built from the requirements
    int m_cnt = 0, m_act = 1, nc, na;
    logic m_str = 1'b0, m_sq = 1'b0;

    always #4 clk = ~clk;

    ratio_clk_divider #(.RATIO_W(RW)) u_dut (
        .clk(clk), .rst(rst), .en(en), .ratio(ratio),
        .strobe(strobe), .sq_out(sq_out)
    );

    function automatic int eff(input logic [RW-1:0] r);
        return (r == 0) ? 1 : int'(r);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_act <= eff(ratio); m_str <= 1'b0; m_sq <= 1'b0;
        end else if (en) begin
            nc = (m_cnt == m_act - 1) ? 0 : m_cnt + 1;
            na = (m_cnt == m_act - 1) ? eff(ratio) : m_act;
            m_cnt <= nc; m_act <= na;
            m_str <= (nc == na - 1);
            m_sq  <= (nc >= na / 2);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one edge, then compare against the reference away from the edge
    task automatic step();
        @(posedge clk); #2;
        check(strobe == m_str, "R10 strobe", strobe, m_str);
        check(sq_out == m_sq,  "R10 square", sq_out, m_sq);
    endtask

    task automatic do_reset(input logic [RW-1:0] r);
        rst = 1'b1; en = 1'b1; ratio = r;
        step(); step();
        check(strobe == 1'b0 && sq_out == 1'b0, "R3 outputs low in reset", {strobe, sq_out}, 0);
        rst = 1'b0;
    endtask

    task automatic t_div10();
        int strobes = 0, rises = 0;
        logic prev;
        do_reset(8'd10);
        for (int i = 0; i < 9; i++) step();
        check(strobe == 1'b1, "R2 first strobe after 9 edges", strobe, 1);
        prev = sq_out;
        for (int i = 0; i < 20; i++) begin
            step();
            if (strobe) strobes++;
            if (sq_out && !prev) rises++;
            prev = sq_out;
        end
        check(strobes == 2, "R6 strobes in 20 cycles", strobes, 2);
        check(rises == 2,   "R6 square rises in 20 cycles", rises, 2);
    endtask

    task automatic t_duty(input int n);
        int hi = 0;
        do_reset(RW'(n));
        for (int i = 0; i < 2 * n; i++) begin
            step();
            if (sq_out) hi++;
        end
        check(hi == 2 * ((n + 1) / 2), "R4 square high cycles", hi, 2 * ((n + 1) / 2));
    endtask

    task automatic t_pow2();
        do_reset(8'd8);
        for (int i = 1; i <= 16; i++) begin
            step();
            check(sq_out == ((i % 8) >= 4), "R5 square equals count bit 2", sq_out, int'((i % 8) >= 4));
        end
    endtask

    task automatic t_one(input logic [RW-1:0] r, input string tag);
        do_reset(r);
        for (int i = 0; i < 6; i++) begin
            step();
            check(strobe && sq_out, tag, {strobe, sq_out}, 3);
        end
    endtask

    task automatic t_change();
        int gap = 0;
        do_reset(8'd6);
        step(); step();
        ratio = 8'd3;                       // mid-period: old length must finish
        for (int i = 0; i < 3; i++) step();
        check(strobe == 1'b1, "R7 old period kept length 6", strobe, 1);
        for (int i = 0; i < 3; i++) step();
        check(strobe == 1'b1, "R7 new period length 3", strobe, 1);
        ratio = 8'd5;                       // changed in the strobe cycle itself
        do begin step(); gap++; end while (!strobe && gap < 20);
        check(gap == 5, "R7 ratio taken on wrap edge", gap, 5);
    endtask

    task automatic t_enable();
        logic s0, q0;
        do_reset(8'd4);
        for (int i = 0; i < 3; i++) step();  // strobe high now
        en = 1'b0; s0 = strobe; q0 = sq_out;
        for (int i = 0; i < 5; i++) begin
            step();
            check(strobe == s0 && sq_out == q0, "R9 outputs frozen", {strobe, sq_out}, {s0, q0});
        end
        check(s0 == 1'b1, "R9 strobe held through disable", s0, 1);
        en = 1'b1;
        step();
        check(strobe == 1'b0 && sq_out == 1'b0, "R9 resumes at count 0", {strobe, sq_out}, 0);
        for (int i = 0; i < 8; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        t_div10();
        t_duty(5);
        t_duty(6);
        t_duty(3);
        t_pow2();
        t_one(8'd1, "R8 ratio 1 both high");
        t_one(8'd0, "R1 ratio 0 acts as 1");
        t_change();
        t_enable();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule